// File: doc/BRIEF.md
# Accumulator Execute-Stage ALU

This block is the arithmetic and logic unit of the execute stage of a small 32-bit accumulator-style processor. Each cycle it receives a full 32-bit instruction word, the values of the two registers that the instruction names, and a memory operand that an earlier stage has already fetched. From these it computes the new value of the first (accumulator) register. The operations are add, subtract, AND, OR, XOR, logical shift left and logical shift right. A single instruction bit turns the three logic operations into their inverted forms.

The instruction word selects how the second operand is formed. In register mode the two register values are combined. In immediate mode the second register and the 16-bit immediate are folded into one three-input operation, and the register term drops out when the second register index is zero. The two memory modes combine the accumulator with the supplied memory operand.

When the caller raises the execute strobe, the block registers the result, the destination index and a one-cycle write pulse for the register file. Without the strobe, nothing moves.

Top module: `accum_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `wr_en`, `wr_idx` and `wr_data` become 0.
- R2: At a clock edge where `exec_en` is high and the opcode (bits 31-27) is one of add=00001, sub=00011, and=00101, or=00111, xor=01011, sll=01101 or srl=01111, the next cycle shows `wr_en`=1, `wr_idx` equal to the instruction's bits 23-20, and `wr_data` equal to the result. `wr_en` falls at the next edge without a strobe.
- R3: At an edge where `exec_en` is low, `wr_en` goes to 0 and `wr_data` and `wr_idx` keep their values, whatever the other inputs are.
- R4: A strobe with any other opcode raises no write pulse and leaves `wr_data` unchanged.
- R5: In access mode 0 (bits 25-24 = 0) the result is R1 op R2.
- R6: In access mode 1 with a nonzero second register index (bits 19-16), the result is (R1 op R2) op imm, where imm is bits 15-0. Subtract gives R1-R2-imm. A shift is applied first by R2 and then by imm.
- R7: In access mode 1 with second register index 0, the result is R1 op imm, and `r2_val` has no effect. The immediate is zero-extended to 32 bits.
- R8: In access modes 2 and 3 the result is R1 op `mem_val`, and `r2_val` has no effect.
- R9: When bit 26 is 1, the results of and, or and xor are inverted (nand, nor, xnor). For add, sub, sll and srl, bit 26 has no effect.
- R10: Add and subtract wrap modulo 2^32.
- R11: Shifts fill with zeros. A shift amount that has any bit from bit 5 upward set gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; the result is captured on an edge where it is high |
| instr | input | 32 | Instruction word being executed |
| r1_val | input | 32 | Value of the first (accumulator) register |
| r2_val | input | 32 | Value of the second register |
| mem_val | input | 32 | Memory operand already fetched for modes 2 and 3 |
| wr_en | output | 1 | One-cycle write pulse to the register file |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | New value for the destination register |

## Verification
Every result is due exactly one clock edge after the strobed edge that captured it. The bench therefore drives the instruction and operands on a falling edge, lets one rising edge pass, and reads `wr_en`, `wr_idx` and `wr_data` on the following falling edge. The cycles without a strobe, and the back-to-back strobes, are checked at that same half-cycle offset. This tests both that the pulse drops after one cycle and that the held data does not move while unrelated inputs change.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned OPC_W   = 5;
    localparam int unsigned RIDX_W  = 4;
    localparam int unsigned IMM_W   = 16;

    localparam logic [OPC_W-1:0] OPC_ADD = 5'b00001;
    localparam logic [OPC_W-1:0] OPC_SUB = 5'b00011;
    localparam logic [OPC_W-1:0] OPC_AND = 5'b00101;
    localparam logic [OPC_W-1:0] OPC_OR  = 5'b00111;
    localparam logic [OPC_W-1:0] OPC_XOR = 5'b01011;
    localparam logic [OPC_W-1:0] OPC_SLL = 5'b01101;
    localparam logic [OPC_W-1:0] OPC_SRL = 5'b01111;

    typedef enum logic [1:0] {
        ACC_REG = 2'd0,
        ACC_IMM = 2'd1,
        ACC_ABS = 2'd2,
        ACC_IDX = 2'd3
    } access_e;

    // Bit layout is fixed by the instruction set: MSB first.
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic              inv;
        access_e           mode;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src;
        logic [IMM_W-1:0]  imm;
    } instr_fields_t;

    function automatic logic is_alu_opc(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_ADD, OPC_SUB, OPC_AND, OPC_OR,
            OPC_XOR, OPC_SLL, OPC_SRL: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

    function automatic logic is_logic_opc(input logic [OPC_W-1:0] opc);
        return (opc == OPC_AND) || (opc == OPC_OR) || (opc == OPC_XOR);
    endfunction

endpackage

// File: rtl/accum_shifter.sv
module accum_shifter #(
    parameter int unsigned W = accum_alu_pkg::XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    input  logic         to_left,
    output logic [W-1:0] y
);
    localparam int unsigned SH_W = $clog2(W);

    logic too_far;

    always_comb begin
        too_far = |amt[W-1:SH_W];
        if (too_far)
            y = '0;
        else if (to_left)
            y = a << amt[SH_W-1:0];
        else
            y = a >> amt[SH_W-1:0];
    end

    // R11: any amount at or beyond the word width empties the word
    always_comb begin
        assert_wide_shift_zero_R11: assert ((amt < W) || (y == '0));
    end

endmodule

// File: rtl/accum_op_unit.sv
module accum_op_unit #(
    parameter int unsigned W = accum_alu_pkg::XLEN
) (
    input  logic [accum_alu_pkg::OPC_W-1:0] opc,
    input  logic [W-1:0]                    a,
    input  logic [W-1:0]                    b,
    output logic [W-1:0]                    y
);
    import accum_alu_pkg::*;

    logic [W-1:0] shifted;

    accum_shifter #(.W(W)) u_shift (
        .a       (a),
        .amt     (b),
        .to_left (opc == OPC_SLL),
        .y       (shifted)
    );

    always_comb begin
        case (opc)
            OPC_ADD: y = a + b;
            OPC_SUB: y = a - b;
            OPC_AND: y = a & b;
            OPC_OR:  y = a | b;
            OPC_XOR: y = a ^ b;
            OPC_SLL,
            OPC_SRL: y = shifted;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/accum_operand_mux.sv
module accum_operand_mux #(
    parameter int unsigned W = accum_alu_pkg::XLEN
) (
    input  accum_alu_pkg::access_e mode,
    input  logic                   src_is_zero,
    input  logic [W-1:0]           r1,
    input  logic [W-1:0]           r2,
    input  logic [W-1:0]           mem,
    input  logic [W-1:0]           imm_ext,
    input  logic [W-1:0]           pre_val,
    output logic [W-1:0]           lhs,
    output logic [W-1:0]           rhs
);
    import accum_alu_pkg::*;

    always_comb begin
        lhs = r1;
        rhs = r2;
        case (mode)
            ACC_REG: begin
                lhs = r1;
                rhs = r2;
            end
            ACC_IMM: begin
                lhs = src_is_zero ? r1 : pre_val;
                rhs = imm_ext;
            end
            ACC_ABS,
            ACC_IDX: begin
                lhs = r1;
                rhs = mem;
            end
            default: begin
                lhs = r1;
                rhs = r2;
            end
        endcase
    end

endmodule

// File: rtl/accum_alu.sv
module accum_alu #(
    parameter int unsigned DATA_W = accum_alu_pkg::XLEN
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              exec_en,
    input  logic [accum_alu_pkg::INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]                 r1_val,
    input  logic [DATA_W-1:0]                 r2_val,
    input  logic [DATA_W-1:0]                 mem_val,
    output logic                              wr_en,
    output logic [accum_alu_pkg::RIDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0]                 wr_data
);
    import accum_alu_pkg::*;

    localparam int unsigned PAD_W = DATA_W - IMM_W;

    instr_fields_t f;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] pre_val;
    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic [DATA_W-1:0] raw_res;
    logic [DATA_W-1:0] final_res;
    logic              do_write;

    assign f        = instr_fields_t'(instr);
    assign imm_ext  = {{PAD_W{1'b0}}, f.imm};
    assign do_write = exec_en && is_alu_opc(f.opc);

    // First stage of the three-input immediate form: R1 op R2
    accum_op_unit #(.W(DATA_W)) u_pre (
        .opc (f.opc),
        .a   (r1_val),
        .b   (r2_val),
        .y   (pre_val)
    );

    accum_operand_mux #(.W(DATA_W)) u_mux (
        .mode        (f.mode),
        .src_is_zero (f.src == '0),
        .r1          (r1_val),
        .r2          (r2_val),
        .mem         (mem_val),
        .imm_ext     (imm_ext),
        .pre_val     (pre_val),
        .lhs         (lhs),
        .rhs         (rhs)
    );

    accum_op_unit #(.W(DATA_W)) u_main (
        .opc (f.opc),
        .a   (lhs),
        .b   (rhs),
        .y   (raw_res)
    );

    assign final_res = (f.inv && is_logic_opc(f.opc)) ? ~raw_res : raw_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= do_write;
            if (do_write) begin
                wr_idx  <= f.dst;
                wr_data <= final_res;
            end
        end
    end

    assert_write_follows_strobe_R2: assert property (
        @(posedge clk) disable iff (rst) wr_en |-> $past(exec_en));

    assert_index_from_field_R2: assert property (
        @(posedge clk) disable iff (rst) wr_en |-> (wr_idx == $past(instr[23:20])));

    assert_idle_holds_R3: assert property (
        @(posedge clk) disable iff (rst)
        !exec_en |=> (!wr_en && $stable(wr_data) && $stable(wr_idx)));

    assert_foreign_opcode_silent_R4: assert property (
        @(posedge clk) disable iff (rst)
        (exec_en && !is_alu_opc(instr[31:27])) |=> (!wr_en && $stable(wr_data)));

endmodule

// File: tb/test_accum_alu.sv
module test_accum_alu;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] r1_val = '0;
    logic [31:0] r2_val = '0;
    logic [31:0] mem_val = '0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    accum_alu i_accum_alu (
        .clk     (clk),
        .rst     (rst),
        .exec_en (exec_en),
        .instr   (instr),
        .r1_val  (r1_val),
        .r2_val  (r2_val),
        .mem_val (mem_val),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    function automatic logic [31:0] enc(input logic [4:0] opc, input logic inv,
                                        input logic [1:0] mode, input logic [3:0] dst,
                                        input logic [3:0] src, input logic [15:0] imm);
        return {opc, inv, mode, dst, src, imm};
    endfunction

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] m;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R5 register mode
        '{8'd5,  enc(5'h01,1'b0,2'd0,4'd1,4'd2,16'h0000), 32'd5, 32'd7, 32'h0, 32'h0000000C},
        '{8'd5,  enc(5'h03,1'b0,2'd0,4'd2,4'd3,16'h0000), 32'd3, 32'd5, 32'h0, 32'hFFFFFFFE},
        // R6 three-input immediate
        '{8'd6,  enc(5'h01,1'b0,2'd1,4'd3,4'd2,16'h0003), 32'h10, 32'h20, 32'h0, 32'h00000033},
        '{8'd6,  enc(5'h03,1'b0,2'd1,4'd4,4'd5,16'h0004), 32'h64, 32'h10, 32'h0, 32'h00000050},
        // R7 index 0 drops r2, immediate zero-extended
        '{8'd7,  enc(5'h01,1'b0,2'd1,4'd5,4'd0,16'hFFFF), 32'd1, 32'h0000FFFF, 32'h0, 32'h00010000},
        // R8 memory modes, r2 ignored
        '{8'd8,  enc(5'h05,1'b0,2'd2,4'd6,4'd0,16'h0040), 32'hFF00FF00, 32'h0, 32'h0FF00FF0, 32'h0F000F00},
        '{8'd8,  enc(5'h07,1'b0,2'd3,4'd7,4'd9,16'h0010), 32'h00000001, 32'h12345678, 32'h80000000, 32'h80000001},
        // R9 inverted logic
        '{8'd9,  enc(5'h05,1'b1,2'd0,4'd8,4'd1,16'h0000), 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'h0FFF0FFF},
        '{8'd9,  enc(5'h07,1'b1,2'd1,4'd9,4'd0,16'h00FF), 32'h0, 32'hDEADBEEF, 32'h0, 32'hFFFFFF00},
        '{8'd9,  enc(5'h0B,1'b1,2'd2,4'd10,4'd0,16'h0001), 32'hAAAAAAAA, 32'h0, 32'hAAAAAAAA, 32'hFFFFFFFF},
        '{8'd9,  enc(5'h01,1'b1,2'd0,4'd11,4'd1,16'h0000), 32'd2, 32'd3, 32'h0, 32'h00000005},
        // R10 wrap-around
        '{8'd10, enc(5'h01,1'b0,2'd0,4'd12,4'd1,16'h0000), 32'hFFFFFFFF, 32'd2, 32'h0, 32'h00000001},
        '{8'd10, enc(5'h03,1'b0,2'd1,4'd13,4'd0,16'h0001), 32'h0, 32'h5, 32'h0, 32'hFFFFFFFF},
        // R11 shifts
        '{8'd11, enc(5'h0D,1'b0,2'd0,4'd14,4'd1,16'h0000), 32'h1, 32'd31, 32'h0, 32'h80000000},
        '{8'd11, enc(5'h0F,1'b0,2'd0,4'd15,4'd1,16'h0000), 32'h80000000, 32'd32, 32'h0, 32'h00000000},
        '{8'd11, enc(5'h0D,1'b0,2'd0,4'd1,4'd1,16'h0000), 32'h1, 32'h00000100, 32'h0, 32'h00000000},
        '{8'd11, enc(5'h0F,1'b0,2'd2,4'd2,4'd0,16'h0000), 32'hF0000000, 32'h0, 32'd4, 32'h0F000000},
        '{8'd11, enc(5'h0F,1'b0,2'd1,4'd3,4'd0,16'h0020), 32'hFFFFFFFF, 32'h0, 32'h0, 32'h00000000},
        // R6 shifts and logic in three-input form
        '{8'd6,  enc(5'h0D,1'b0,2'd1,4'd4,4'd2,16'h0003), 32'h1, 32'd4, 32'h0, 32'h00000080},
        '{8'd6,  enc(5'h0B,1'b0,2'd1,4'd5,4'd2,16'h00F0), 32'hFF, 32'h0F, 32'h0, 32'h00000000},
        '{8'd6,  enc(5'h0F,1'b0,2'd1,4'd6,4'd2,16'h000C), 32'h80000000, 32'd20, 32'h0, 32'h00000000},
        '{8'd9,  enc(5'h05,1'b1,2'd1,4'd7,4'd3,16'h00F0), 32'hFFFFFFFF, 32'h0000FFFF, 32'h0, 32'hFFFFFF0F}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] m);
        instr   = ins;
        r1_val  = a;
        r2_val  = b;
        mem_val = m;
        exec_en = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] held;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 wr_en in reset", {31'd0, wr_en}, 32'd0);
        check("R1 wr_idx in reset", {28'd0, wr_idx}, 32'd0);
        check("R1 wr_data in reset", wr_data, 32'd0);
        rst = 1'b0;

        // Table walk: drive on falling edge, one rising edge, read on next falling edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            issue(VECS[i].ins, VECS[i].a, VECS[i].b, VECS[i].m);
            @(negedge clk);
            exec_en = 1'b0;
            check($sformatf("R%0d vector %0d wr_data", VECS[i].req, i), wr_data, VECS[i].exp);
            check($sformatf("R2 vector %0d wr_en", i), {31'd0, wr_en}, 32'd1);
            check($sformatf("R2 vector %0d wr_idx", i), {28'd0, wr_idx}, {28'd0, VECS[i].ins[23:20]});
        end

        // R2/R3: pulse lasts one cycle, data holds while idle and inputs move
        held = wr_data;
        instr  = enc(5'h01, 1'b0, 2'd0, 4'd9, 4'd1, 16'h0000);
        r1_val = 32'h11111111;
        r2_val = 32'h22222222;
        @(negedge clk);
        check("R2 pulse dropped", {31'd0, wr_en}, 32'd0);
        check("R3 data held while idle", wr_data, held);
        check("R3 index held while idle", {28'd0, wr_idx}, 32'd7);

        // R4: strobe with a non-ALU opcode (00010)
        issue(enc(5'h02, 1'b0, 2'd0, 4'd3, 4'd1, 16'h0000), 32'h5, 32'h6, 32'h0);
        @(negedge clk);
        exec_en = 1'b0;
        check("R4 no pulse for foreign opcode", {31'd0, wr_en}, 32'd0);
        check("R4 data unchanged", wr_data, held);

        // R2: back-to-back strobes
        issue(enc(5'h01, 1'b0, 2'd0, 4'd2, 4'd1, 16'h0000), 32'd10, 32'd20, 32'h0);
        @(negedge clk);
        check("R2 first of pair", wr_data, 32'd30);
        issue(enc(5'h07, 1'b0, 2'd1, 4'd4, 4'd0, 16'h0F00), 32'h000000F0, 32'hFFFFFFFF, 32'h0);
        @(negedge clk);
        exec_en = 1'b0;
        check("R2 second of pair data", wr_data, 32'h00000FF0);
        check("R2 second of pair index", {28'd0, wr_idx}, 32'd4);
        check("R2 second of pair pulse", {31'd0, wr_en}, 32'd1);

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1 data cleared by reset", wr_data, 32'd0);
        check("R1 pulse cleared by reset", {31'd0, wr_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end

endmodule